// File: doc/BRIEF.md
# Reconfigurable Aspect-Ratio Block RAM

This block is a 147,456-bit synchronous memory whose shape is chosen by a static three-bit configuration input. The same storage can be a single 72-bit-wide port 2048 words deep, or a 36-, 18- or 9-bit port that is correspondingly deeper. The three narrower widths can also be used as two independent ports that share one clock. Each port has its own address and write enable. In the dual-port shapes, the single 72-bit write-data bus and the single 72-bit read-data bus are each split between the two ports.

Internally there are always 2048 physical rows of eight 9-bit lanes. A narrow word is held in a group of adjacent lanes. The low eleven address bits select the row, and the address bits just above them select which lane group of that row is used. Every access completes in one cycle and the block never stalls, so it has no back-pressure. A new access is accepted on every clock edge, and its read word appears one cycle later.

Top module: `bram_mode_ram`

## Requirements
- R1: While `rst_n` is low, `rd_data` is all zeros.
- R2: With `cfg_mode`=0 (2048x72, one port), a write stores all 72 bits of `wr_data` at row `a_addr[10:0]`, and `a_addr[16:11]` has no effect on the row chosen.
- R3: Read data is registered. `rd_data` shows the word at the address that was sampled on the previous rising edge.
- R4: If a word is read and written in the same cycle, `rd_data` returns the contents from before the write (read-first).
- R5: With `cfg_mode`=1 (4096x36, one port), the word address is `a_addr[11:0]`. The data uses `wr_data[35:0]` and `rd_data[35:0]`, and `rd_data[71:36]` reads zero.
- R6: With `cfg_mode`=3 (8192x18, one port), the word address is `a_addr[12:0]`. The data uses bits [17:0], and all higher output bits are zero.
- R7: With `cfg_mode`=5 (16384x9, one port), the word address is `a_addr[13:0]`. The data uses bits [8:0], and all higher output bits are zero.
- R8: The dual-port modes are `cfg_mode`=2 (36-bit), 4 (18-bit) and 6 (9-bit). In these modes, port A uses bits [W-1:0] and port B uses bits [2W-1:W] of both data buses, and output bits at and above 2W are zero.
- R9: In the single-port modes, `b_wen` and `b_addr` change no stored data.
- R10: In a dual-port mode, if both ports write the same word in one cycle, port B's data is stored.
- R11: A narrow write changes only its own lane group. Two writes to different lane groups of the same physical row in the same cycle both take effect.
- R12: With `cfg_mode`=7 (disabled), nothing is written, and `rd_data` is zero in the cycle after.
- R13: A narrow word at address {s, r} occupies bits [s*W +: W] of the 72-bit word at row r.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset of the output path |
| cfg_mode | input | 3 | Shape select: 0 W72 SP, 1 W36 SP, 2 W36 DP, 3 W18 SP, 4 W18 DP, 5 W9 SP, 6 W9 DP, 7 off |
| a_addr | input | 17 | Port A word address |
| b_addr | input | 17 | Port B word address (dual-port modes) |
| wr_data | input | 72 | Write data; split between the ports in the dual-port modes |
| a_wen | input | 1 | Port A write enable |
| b_wen | input | 1 | Port B write enable (dual-port modes) |
| rd_data | output | 72 | Registered read data; unused bits are zero |

## Verification
The hardest case to reach is two writes in one cycle to different lane groups of the same physical row. Both writes must merge into the row, and no lane may be lost. The stimulus first fills a row through the 72-bit shape. It then switches to the 9-bit dual-port shape and gives the two ports addresses that differ only in their lane-select bits. Finally it switches back to the 72-bit shape and reads the whole row, so that every lane can be compared with its expected value.

// File: rtl/bram_cfg_pkg.sv
package bram_cfg_pkg;

  typedef enum logic [2:0] {
    CFG_W72_SP = 3'd0,
    CFG_W36_SP = 3'd1,
    CFG_W36_DP = 3'd2,
    CFG_W18_SP = 3'd3,
    CFG_W18_DP = 3'd4,
    CFG_W9_SP  = 3'd5,
    CFG_W9_DP  = 3'd6,
    CFG_OFF    = 3'd7
  } bram_cfg_e;

  // Narrowing level: a word spans SLICES >> level lanes.
  function automatic int cfg_level(bram_cfg_e c);
    case (c)
      CFG_W36_SP, CFG_W36_DP: return 1;
      CFG_W18_SP, CFG_W18_DP: return 2;
      CFG_W9_SP,  CFG_W9_DP:  return 3;
      default:                return 0;
    endcase
  endfunction

  function automatic logic cfg_dual(bram_cfg_e c);
    return (c == CFG_W36_DP) || (c == CFG_W18_DP) || (c == CFG_W9_DP);
  endfunction

  function automatic logic cfg_live(bram_cfg_e c);
    return c != CFG_OFF;
  endfunction

endpackage

// File: rtl/bram_port_map.sv
module bram_port_map #(
  parameter int SLICE_W = 9,
  parameter int SLICES  = 8,
  parameter int ROW_AW  = 11,
  parameter int ADDR_W  = 17,
  parameter int LVL_W   = 2
) (
  input  logic [LVL_W-1:0]              level,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [SLICE_W*SLICES-1:0]     wsrc,
  output logic [ROW_AW-1:0]             row,
  output logic [$clog2(SLICES)-1:0]     slot,
  output logic [SLICES-1:0]             lane_mask,
  output logic [SLICE_W*SLICES-1:0]     wrow
);
  localparam int SEL_W = $clog2(SLICES);

  always_comb begin
    int lanes;
    int first;
    logic [SEL_W-1:0] slot_v;
    lanes  = SLICES >> level;
    slot_v = SEL_W'(addr >> ROW_AW) & SEL_W'((1 << level) - 1);
    first  = int'(slot_v) * lanes;
    row    = addr[ROW_AW-1:0];
    slot   = slot_v;
    lane_mask = '0;
    wrow      = '0;
    for (int i = 0; i < SLICES; i++) begin
      if (i >= first && i < first + lanes) begin
        lane_mask[i] = 1'b1;
        wrow[i*SLICE_W +: SLICE_W] = wsrc[(i-first)*SLICE_W +: SLICE_W];
      end
    end
  end

endmodule

// File: rtl/bram_store.sv
module bram_store #(
  parameter int SLICE_W = 9,
  parameter int SLICES  = 8,
  parameter int ROW_AW  = 11
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we_a,
  input  logic [ROW_AW-1:0]             row_a,
  input  logic [SLICES-1:0]             mask_a,
  input  logic [SLICE_W*SLICES-1:0]     wrow_a,
  input  logic                          we_b,
  input  logic [ROW_AW-1:0]             row_b,
  input  logic [SLICES-1:0]             mask_b,
  input  logic [SLICE_W*SLICES-1:0]     wrow_b,
  output logic [SLICE_W*SLICES-1:0]     rd_a,
  output logic [SLICE_W*SLICES-1:0]     rd_b
);
  localparam int ROW_W = SLICE_W * SLICES;
  localparam int ROWS  = 1 << ROW_AW;

  logic [ROW_W-1:0] mem [ROWS];
  logic [ROW_W-1:0] bm_a, bm_b, merged;
  logic             same_row;

  always_comb begin
    for (int i = 0; i < SLICES; i++) begin
      bm_a[i*SLICE_W +: SLICE_W] = {SLICE_W{mask_a[i]}};
      bm_b[i*SLICE_W +: SLICE_W] = {SLICE_W{mask_b[i]}};
    end
    same_row = we_a && we_b && (row_a == row_b);
    // Port A applied first, port B on top: B wins on overlapping lanes.
    merged = (((mem[row_a] & ~bm_a) | (wrow_a & bm_a)) & ~bm_b) | (wrow_b & bm_b);
  end

  always_ff @(posedge clk) begin
    if (same_row) begin
      mem[row_a] <= merged;
    end else begin
      if (we_a) mem[row_a] <= (mem[row_a] & ~bm_a) | (wrow_a & bm_a);
      if (we_b) mem[row_b] <= (mem[row_b] & ~bm_b) | (wrow_b & bm_b);
    end
    rd_a <= mem[row_a];
    rd_b <= mem[row_b];
  end

  AST_A_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (we_a && !(we_b && row_b == row_a)) |=>
      ((mem[$past(row_a)] & $past(bm_a)) == ($past(wrow_a) & $past(bm_a)))); // R2
  AST_B_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    same_row |=> ((mem[$past(row_b)] & $past(bm_b)) == ($past(wrow_b) & $past(bm_b)))); // R10
  AST_KEEP_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (we_a && !we_b) |=>
      ((mem[$past(row_a)] & ~$past(bm_a)) == ($past(mem[row_a]) & ~$past(bm_a)))); // R11

endmodule

// File: rtl/bram_out_sel.sv
module bram_out_sel #(
  parameter int SLICE_W = 9,
  parameter int SLICES  = 8,
  parameter int LVL_W   = 2
) (
  input  logic [SLICE_W*SLICES-1:0]     row_a,
  input  logic [SLICE_W*SLICES-1:0]     row_b,
  input  logic [$clog2(SLICES)-1:0]     slot_a,
  input  logic [$clog2(SLICES)-1:0]     slot_b,
  input  logic [LVL_W-1:0]              level,
  input  logic                          dual,
  input  logic                          live,
  output logic [SLICE_W*SLICES-1:0]     dout
);
  localparam int ROW_W = SLICE_W * SLICES;

  always_comb begin
    int ww;
    logic [ROW_W-1:0] wmask, word_a, word_b;
    ww     = SLICE_W * (SLICES >> level);
    wmask  = (ROW_W'(1) << ww) - ROW_W'(1);
    word_a = (row_a >> (int'(slot_a) * ww)) & wmask;
    word_b = (row_b >> (int'(slot_b) * ww)) & wmask;
    if (!live)     dout = '0;
    else if (dual) dout = word_a | (word_b << ww);
    else           dout = word_a;
  end

endmodule

// File: rtl/bram_mode_ram.sv
module bram_mode_ram
  import bram_cfg_pkg::*;
#(
  parameter int SLICE_W = 9,
  parameter int SLICES  = 8,
  parameter int ROW_AW  = 11,
  parameter int ADDR_W  = 17
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [2:0]                cfg_mode,
  input  logic [ADDR_W-1:0]         a_addr,
  input  logic [ADDR_W-1:0]         b_addr,
  input  logic [SLICE_W*SLICES-1:0] wr_data,
  input  logic                      a_wen,
  input  logic                      b_wen,
  output logic [SLICE_W*SLICES-1:0] rd_data
);
  localparam int ROW_W = SLICE_W * SLICES;
  localparam int SEL_W = $clog2(SLICES);
  localparam int LVL_W = $clog2(SEL_W + 1);

  bram_cfg_e         cfg;
  logic [LVL_W-1:0]  level;
  logic              dual, live;
  logic [ROW_W-1:0]  src [2];
  logic [ADDR_W-1:0] paddr [2];
  logic [ROW_AW-1:0] prow [2];
  logic [SEL_W-1:0]  pslot [2];
  logic [SLICES-1:0] pmask [2];
  logic [ROW_W-1:0]  pwrow [2];
  logic [ROW_W-1:0]  rrow [2];
  logic              we_a, we_b;

  logic [LVL_W-1:0]  level_q;
  logic              dual_q, live_q;
  logic [SEL_W-1:0]  slot_q [2];

  always_comb begin
    int ww;
    cfg   = bram_cfg_e'(cfg_mode);
    level = LVL_W'(cfg_level(cfg));
    dual  = cfg_dual(cfg);
    live  = cfg_live(cfg);
    ww    = SLICE_W * (SLICES >> level);
    src[0]   = wr_data;
    src[1]   = wr_data >> ww;
    paddr[0] = a_addr;
    paddr[1] = b_addr;
    we_a  = a_wen && live;
    we_b  = b_wen && live && dual;
  end

  for (genvar p = 0; p < 2; p++) begin : g_port
    bram_port_map #(
      .SLICE_W(SLICE_W), .SLICES(SLICES), .ROW_AW(ROW_AW),
      .ADDR_W(ADDR_W), .LVL_W(LVL_W)
    ) map_i (
      .level(level), .addr(paddr[p]), .wsrc(src[p]),
      .row(prow[p]), .slot(pslot[p]), .lane_mask(pmask[p]), .wrow(pwrow[p])
    );
  end

  bram_store #(.SLICE_W(SLICE_W), .SLICES(SLICES), .ROW_AW(ROW_AW)) store_i (
    .clk(clk), .rst_n(rst_n),
    .we_a(we_a), .row_a(prow[0]), .mask_a(pmask[0]), .wrow_a(pwrow[0]),
    .we_b(we_b), .row_b(prow[1]), .mask_b(pmask[1]), .wrow_b(pwrow[1]),
    .rd_a(rrow[0]), .rd_b(rrow[1])
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q   <= '0;
      dual_q    <= 1'b0;
      live_q    <= 1'b0;
      slot_q[0] <= '0;
      slot_q[1] <= '0;
    end else begin
      level_q   <= level;
      dual_q    <= dual;
      live_q    <= live;
      slot_q[0] <= pslot[0];
      slot_q[1] <= pslot[1];
    end
  end

  bram_out_sel #(.SLICE_W(SLICE_W), .SLICES(SLICES), .LVL_W(LVL_W)) out_i (
    .row_a(rrow[0]), .row_b(rrow[1]), .slot_a(slot_q[0]), .slot_b(slot_q[1]),
    .level(level_q), .dual(dual_q), .live(live_q), .dout(rd_data)
  );

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cfg_mode) == 3'd7) |-> (rd_data == '0)); // R12
  AST_W36_SP_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cfg_mode) == 3'd1) |-> (rd_data[ROW_W-1:ROW_W/2] == '0)); // R5
  AST_W18_DP_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cfg_mode) == 3'd4) |-> (rd_data[ROW_W-1:ROW_W/2] == '0)); // R8
  AST_W9_SP_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cfg_mode) == 3'd5) |-> (rd_data[ROW_W-1:SLICE_W] == '0)); // R7

endmodule

// File: tb/bram_mode_ram_tb_top.sv
module bram_mode_ram_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cfg_mode = 3'd0;
  logic [16:0] a_addr = '0, b_addr = '0;
  logic [71:0] wr_data = '0;
  logic        a_wen = 1'b0, b_wen = 1'b0;
  logic [71:0] rd_data;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  bram_mode_ram dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .a_addr(a_addr), .b_addr(b_addr),
    .wr_data(wr_data), .a_wen(a_wen), .b_wen(b_wen), .rd_data(rd_data)
  );

  function automatic logic [16:0] at(input int slot, input int row);
    return 17'((slot << 11) | row);
  endfunction

  task automatic chk(input string tag, input logic [71:0] act, input logic [71:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One access cycle; returns with rd_data showing this cycle's read.
  task automatic op(input logic [2:0] m, input logic [16:0] aa, input logic [16:0] ba,
                    input logic [71:0] d, input logic aw, input logic bw);
    cfg_mode = m; a_addr = aa; b_addr = ba; wr_data = d; a_wen = aw; b_wen = bw;
    @(posedge clk); #1;
    a_wen = 1'b0; b_wen = 1'b0;
  endtask

  task automatic t_reset;
    repeat (3) @(posedge clk);
    #1 chk("R1 reset output", rd_data, 72'h0);
    rst_n = 1'b1;
  endtask

  task automatic t_wide;
    logic [71:0] d1 = 72'h12_3456_789A_BCDE_F012;
    logic [71:0] d2 = 72'hA5_5A5A_C3C3_0FF0_1234;
    logic [71:0] d3 = 72'h0F_EDCB_A987_6543_2101;
    op(0, 17'd5, 0, d1, 1, 0);
    op(0, 17'h1F806, 0, d2, 1, 0);
    op(0, 17'd5, 0, 72'h0, 0, 0);
    chk("R3 read after one cycle", rd_data, d1);
    op(0, 17'd6, 0, 72'h0, 0, 0);
    chk("R2 upper addr bits ignored", rd_data, d2);
    op(0, 17'd5, 0, d3, 1, 0);
    chk("R4 read-first old data", rd_data, d1);
    op(0, 17'd5, 0, 72'h0, 0, 0);
    chk("R4 new data after write", rd_data, d3);
  endtask

  task automatic t_w36;
    logic [35:0] x = 36'h9_8765_4321;
    op(1, at(1, 5), 0, {36'hF_FFFF_FFFF, x}, 1, 0);
    op(1, at(1, 5), 0, 72'h0, 0, 0);
    chk("R5 w36 word, upper zero", rd_data, {36'h0, x});
    op(0, 17'd5, 0, 72'h0, 0, 0);
    chk("R13 w36 slot1 in upper half, R11 lower kept", rd_data, {x, 36'h7_6543_2101});
  endtask

  task automatic t_w18;
    op(3, at(2, 7), 0, {54'h3F_FFFF_FFFF_FFFF, 18'h2_B3C4}, 1, 0);
    op(3, at(2, 7), 0, 72'h0, 0, 0);
    chk("R6 w18 word", rd_data, {54'h0, 18'h2_B3C4});
  endtask

  task automatic t_w9;
    logic [71:0] p = 72'h11_2233_4455_6677_8899;
    logic [71:0] e;
    op(0, 17'd8, 0, p, 1, 0);
    op(5, at(7, 8), 0, {63'h7FFF_FFFF_FFFF_FFFF, 9'h1A5}, 1, 0);
    op(5, at(7, 8), 0, 72'h0, 0, 0);
    chk("R7 w9 word", rd_data, {63'h0, 9'h1A5});
    e = p; e[63 +: 9] = 9'h1A5;
    op(0, 17'd8, 0, 72'h0, 0, 0);
    chk("R13 w9 slot7 is top lane", rd_data, e);
  endtask

  task automatic t_dual;
    logic [35:0] x = 36'h1_2345_6789, y = 36'hA_BCDE_F012;
    op(2, at(0, 9), at(1, 10), {y, x}, 1, 1);
    op(2, at(0, 9), at(1, 10), 72'h0, 0, 0);
    chk("R8 w36 dual halves", rd_data, {y, x});
    op(4, at(3, 11), at(0, 12), {36'hF_FFFF_FFFF, 18'h1_1111, 18'h2_2222}, 1, 1);
    op(4, at(3, 11), at(0, 12), 72'h0, 0, 0);
    chk("R8 w18 dual, upper zero", rd_data, {36'h0, 18'h1_1111, 18'h2_2222});
  endtask

  task automatic t_same_row;
    logic [71:0] p = 72'hDE_ADBE_EFCA_FEF0_0D11;
    logic [71:0] e;
    op(0, 17'd13, 0, p, 1, 0);
    op(6, at(4, 13), at(6, 13), {54'h0, 9'h0AA, 9'h155}, 1, 1);
    op(6, at(4, 13), at(6, 13), 72'h0, 0, 0);
    chk("R8 w9 dual, upper zero", rd_data, {54'h0, 9'h0AA, 9'h155});
    e = p; e[36 +: 9] = 9'h155; e[54 +: 9] = 9'h0AA;
    op(0, 17'd13, 0, 72'h0, 0, 0);
    chk("R11 two slots same row both land", rd_data, e);
  endtask

  task automatic t_collide;
    op(4, at(1, 14), at(1, 14), {36'h0, 18'h3_0303, 18'h0_C0C0}, 1, 1);
    op(4, at(1, 14), at(1, 14), 72'h0, 0, 0);
    chk("R10 port B wins collision", rd_data, {36'h0, 18'h3_0303, 18'h3_0303});
  endtask

  task automatic t_sp_ignore;
    logic [71:0] p = 72'h5C_0FFE_E5EE_D5B0_0B1E;
    op(0, 17'd30, 0, p, 1, 0);
    op(1, at(0, 31), at(0, 30), {36'hB_BBBB_BBBB, 36'hA_AAAA_AAAA}, 1, 1);
    op(0, 17'd30, 0, 72'h0, 0, 0);
    chk("R9 port B ignored in single-port mode", rd_data, p);
  endtask

  task automatic t_off;
    logic [71:0] p = 72'h77_6655_4433_2211_0099;
    op(0, 17'd40, 0, p, 1, 0);
    op(7, 17'd40, 17'd40, 72'hFF_FFFF_FFFF_FFFF_FFFF, 1, 1);
    chk("R12 off mode output zero", rd_data, 72'h0);
    op(0, 17'd40, 0, 72'h0, 0, 0);
    chk("R12 off mode wrote nothing", rd_data, p);
  endtask

  initial begin
    t_reset();
    t_wide();
    t_w36();
    t_w18();
    t_w9();
    t_dual();
    t_same_row();
    t_collide();
    t_sp_ignore();
    t_off();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule